// File: doc/BRIEF.md
# Host Parallel Mailbox Interface

This block is the device-side slave of an asynchronous, host-driven parallel bus. Through this bus the host reaches a 4K x 16 shared memory. The host drives an active-low select, a read/write level, a 12-bit word address and a 16-bit data bus. The data bus is split at this boundary into an input, an output and an output enable, and the pad ring's tristate buffer consumes the output enable. All host inputs pass through two-flop synchronizers into the internal clock domain. The block then decodes each bus cycle, captures writes, returns read data and gives the device logic its own synchronous port into the same memory.

The shared memory works as a mailbox. The host pulses an active-low command strobe to say that a command is waiting. The block turns each strobe into exactly one internal one-cycle event. The device logic answers through two independent request inputs, one for data-ready and one for error. Each request produces an active-low pulse toward the host whose width is a parameter counted in clock cycles.

A four-state machine sequences each host bus cycle:
- IDLE goes to READ when the synchronized select is low and R/W is high, and to WRITE when the select is low and R/W is low.
- READ returns to IDLE when the select goes high.
- WRITE keeps capturing the address and data while the select is low, and moves to COMMIT when the select goes high.
- COMMIT writes the captured word into memory for one cycle and returns to IDLE.

Top module: `hpmb_top`

## Requirements
- R1: A bus cycle whose R/W is low when the select falls stores the data word at the address that the host presented just before the select rose.
- R2: While the select is low and R/W is high, `host_dq_o` shows the word at `host_addr` within 4 clock cycles of an address change. It keeps following the address for as long as the select stays low.
- R3: A cycle whose R/W is high at the select's falling edge is a read for its whole duration. Pulling R/W low later in that cycle stores nothing.
- R4: `host_dq_oe` is 1 only while the select is low, R/W is high and the current cycle is not a write. It drops at once when the select rises or R/W falls.
- R5: Each low pulse on `host_cmd_n` lasting at least 2 clock cycles gives exactly one `cmd_pending` cycle, and two `cmd_pending` cycles are never adjacent.
- R6: A one-cycle request on `drdy_req` drives `host_drdy_n` low for exactly PULSE_CYC cycles, starting with the clock edge that samples the request.
- R7: A request that arrives while a pulse of the same kind is active restarts the full PULSE_CYC width from that request.
- R8: `drdy_req` and `err_req` act independently. Both may be asserted in the same cycle, and each then gives its own full pulse.
- R9: While `host_rst_n` is low, `host_drdy_n` and `host_err_n` are 1 and `host_dq_oe` is 0, even if the select is low and R/W is high.
- R10: The device port writes `dev_wdata` at `dev_addr` when `dev_we` is 1. It returns the word at `dev_addr` on `dev_rdata` one clock later. Words written by either side are visible to the other.
- R11: When a host commit and a device write hit the same address in the same cycle, the host word is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| host_rst_n | input | 1 | Active-low reset from the host |
| host_cs_n | input | 1 | Active-low select |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 12 | Word address |
| host_dq_i | input | 16 | Data from the host pad |
| host_dq_o | output | 16 | Read data toward the pad |
| host_dq_oe | output | 1 | Pad output enable |
| host_cmd_n | input | 1 | Active-low command strobe |
| host_drdy_n | output | 1 | Active-low data-ready pulse |
| host_err_n | output | 1 | Active-low error pulse |
| cmd_pending | output | 1 | One-cycle command event |
| drdy_req | input | 1 | Request a data-ready pulse |
| err_req | input | 1 | Request an error pulse |
| dev_we | input | 1 | Device write enable |
| dev_addr | input | 12 | Device word address |
| dev_wdata | input | 16 | Device write data |
| dev_rdata | output | 16 | Device read data, one cycle late |

## Verification
The shared memory is exercised with these patterns:
- Plain writes followed by reads, using the all-ones word at address 0 and a non-trivial word at the top address, so that address decoding at both ends is exposed.
- An address change during a single long read, which separates a read path that follows the address from one that latches it at the select.
- A late fall of R/W during a read, which separates edge-qualified writes from level-qualified ones.
- A device write that lands in the same cycle as a host commit, which shows which writer has priority.

The pulse outputs are compared every cycle against a countdown model under four conditions: a single request, a retrigger, simultaneous requests, and a reset in the middle of a pulse. Together these separate restarting a pulse from ignoring or shortening it.

// File: rtl/hpmb_pkg.sv
package hpmb_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_WRITE,
        BUS_COMMIT
    } bus_state_e;
endpackage

// File: rtl/hpmb_sync.sv
module hpmb_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hpmb_bus_fsm.sv
module hpmb_bus_fsm
    import hpmb_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          rw_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          host_we,
    output logic [AW-1:0] host_waddr,
    output logic [DW-1:0] host_wdata,
    output logic          wr_mode
);
    bus_state_e state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            BUS_IDLE:   if (!cs_s) nxt = rw_s ? BUS_READ : BUS_WRITE;
            BUS_READ:   if (cs_s)  nxt = BUS_IDLE;
            BUS_WRITE:  if (cs_s)  nxt = BUS_COMMIT;
            BUS_COMMIT: nxt = BUS_IDLE;
            default:    nxt = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_we = 1'b0;
        wr_mode = 1'b0;
        unique case (state)
            BUS_WRITE:  wr_mode = 1'b1;
            BUS_COMMIT: begin
                wr_mode = 1'b1;
                host_we = 1'b1;
            end
            default: ;
        endcase
    end

    // keep the last address/data seen while the select is still low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_waddr <= '0;
            host_wdata <= '0;
        end else if (nxt == BUS_WRITE) begin
            host_waddr <= addr_s;
            host_wdata <= data_s;
        end
    end

    assert_commit_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BUS_COMMIT) |-> ($past(state) == BUS_WRITE))
        else $error("commit without a write cycle");

    assert_read_never_commits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BUS_READ) |=> (state != BUS_COMMIT))
        else $error("read cycle turned into a commit");
endmodule

// File: rtl/hpmb_mem.sv
module hpmb_mem #(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic [DW-1:0] host_wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [DW-1:0] host_rdata,
    input  logic          dev_we,
    input  logic [AW-1:0] dev_addr,
    input  logic [DW-1:0] dev_wdata,
    output logic [DW-1:0] dev_rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    // host write is issued last so it wins on a same-address collision
    always_ff @(posedge clk) begin
        if (dev_we)  words[dev_addr]   <= dev_wdata;
        if (host_we) words[host_waddr] <= host_wdata;
        host_rdata <= words[host_raddr];
        dev_rdata  <= words[dev_addr];
    end
endmodule

// File: rtl/hpmb_pulse.sv
module hpmb_pulse #(
    parameter int unsigned CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic out_n
);
    localparam int unsigned CW = $clog2(CYC + 1);

    logic [CW-1:0] remain;
    logic          active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
            active <= 1'b0;
        end else if (req) begin
            remain <= CW'(CYC);
            active <= 1'b1;
        end else begin
            active <= (remain > CW'(1));
            if (remain != '0) remain <= remain - CW'(1);
        end
    end

    assign out_n = ~active;

    // checker: cycles since the latest request
    logic [15:0] since_req;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_req <= '0;
        else if (req)               since_req <= '0;
        else if (since_req != '1)   since_req <= since_req + 16'd1;
    end

    assert_pulse_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> active)
        else $error("pulse did not start on request");

    assert_pulse_min_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (since_req >= 16'(CYC)))
        else $error("pulse ended early after the latest request");
endmodule

// File: rtl/hpmb_top.sv
module hpmb_top #(
    parameter int unsigned AW        = 12,
    parameter int unsigned DW        = 16,
    parameter int unsigned PULSE_CYC = 10
) (
    input  logic          clk,
    input  logic          host_rst_n,
    input  logic          host_cs_n,
    input  logic          host_rw,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_dq_i,
    output logic [DW-1:0] host_dq_o,
    output logic          host_dq_oe,
    input  logic          host_cmd_n,
    output logic          host_drdy_n,
    output logic          host_err_n,
    output logic          cmd_pending,
    input  logic          drdy_req,
    input  logic          err_req,
    input  logic          dev_we,
    input  logic [AW-1:0] dev_addr,
    input  logic [DW-1:0] dev_wdata,
    output logic [DW-1:0] dev_rdata
);
    localparam int unsigned BW = AW + DW;

    // reset: asynchronous assert, synchronous release
    logic [1:0] rst_pipe;
    logic       rst_n_s;
    always_ff @(posedge clk or negedge host_rst_n) begin
        if (!host_rst_n) rst_pipe <= '0;
        else             rst_pipe <= {rst_pipe[0], 1'b1};
    end
    assign rst_n_s = rst_pipe[1];

    // synchronizers
    logic [2:0]    ctl_s;
    logic [BW-1:0] bus_s;
    hpmb_sync #(.W(3), .RST_VAL(3'b111)) u_sync_ctl (
        .clk, .rst_n(rst_n_s),
        .d({host_cs_n, host_rw, host_cmd_n}), .q(ctl_s)
    );
    hpmb_sync #(.W(BW), .RST_VAL('0)) u_sync_bus (
        .clk, .rst_n(rst_n_s),
        .d({host_addr, host_dq_i}), .q(bus_s)
    );

    logic          cs_s, rw_s, cmd_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    assign {cs_s, rw_s, cmd_s} = ctl_s;
    assign addr_s = bus_s[BW-1:DW];
    assign data_s = bus_s[DW-1:0];

    // bus cycle sequencing
    logic          host_we, wr_mode;
    logic [AW-1:0] host_waddr;
    logic [DW-1:0] host_wdata;
    hpmb_bus_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk, .rst_n(rst_n_s),
        .cs_s, .rw_s, .addr_s, .data_s,
        .host_we, .host_waddr, .host_wdata, .wr_mode
    );

    hpmb_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk,
        .host_we, .host_waddr, .host_wdata,
        .host_raddr(addr_s), .host_rdata(host_dq_o),
        .dev_we, .dev_addr, .dev_wdata, .dev_rdata
    );

    // pad enable straight from the pins so release is immediate
    assign host_dq_oe = host_rst_n & rst_n_s & ~host_cs_n & host_rw & ~wr_mode;

    // command strobe falling-edge detect
    logic cmd_prev;
    always_ff @(posedge clk or negedge rst_n_s) begin
        if (!rst_n_s) cmd_prev <= 1'b1;
        else          cmd_prev <= cmd_s;
    end
    assign cmd_pending = cmd_prev & ~cmd_s;

    // answer pulses: [0] data-ready, [1] error
    logic [1:0] pulse_req, pulse_out_n;
    assign pulse_req = {err_req, drdy_req};
    for (genvar g = 0; g < 2; g++) begin : g_pulse
        hpmb_pulse #(.CYC(PULSE_CYC)) u_pulse (
            .clk, .rst_n(rst_n_s), .req(pulse_req[g]), .out_n(pulse_out_n[g])
        );
    end
    assign host_drdy_n = pulse_out_n[0];
    assign host_err_n  = pulse_out_n[1];

    assert_cmd_single_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
        cmd_pending |=> !cmd_pending)
        else $error("command event lasted more than one cycle");

    assert_commit_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
        host_we |-> !host_dq_oe)
        else $error("bus driven during a write commit");

    always @(posedge clk) begin
        if (!host_rst_n) begin
            assert_reset_quiet_R9: assert (host_drdy_n && host_err_n && !host_dq_oe)
                else $error("outputs active during reset");
        end
    end
endmodule

// File: tb/hpmb_top_tb.sv
module hpmb_top_tb;
    localparam int P = 10;

    logic        clk = 1'b0;
    logic        host_rst_n, host_cs_n, host_rw, host_cmd_n;
    logic [11:0] host_addr, dev_addr;
    logic [15:0] host_dq_i, dev_wdata;
    logic [15:0] host_dq_o, dev_rdata;
    logic        host_dq_oe, host_drdy_n, host_err_n, cmd_pending;
    logic        drdy_req, err_req, dev_we;

    int n_chk = 0, n_fail = 0;
    int md = 0, me = 0;
    int pend_cnt = 0;
    bit pend_prev = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hpmb_top #(.AW(12), .DW(16), .PULSE_CYC(P)) u_dut (
        .clk, .host_rst_n, .host_cs_n, .host_rw, .host_addr, .host_dq_i,
        .host_dq_o, .host_dq_oe, .host_cmd_n, .host_drdy_n, .host_err_n,
        .cmd_pending, .drdy_req, .err_req, .dev_we, .dev_addr, .dev_wdata, .dev_rdata
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // reference model for the answer pulses and the command event, every clock
    always @(posedge clk) begin
        if (!host_rst_n) begin
            md = 0;
            me = 0;
        end else begin
            md = drdy_req ? P : (md > 0 ? md - 1 : 0);
            me = err_req  ? P : (me > 0 ? me - 1 : 0);
        end
        #5;
        chk(host_drdy_n == (md == 0), "R6 R7 R8 drdy model", 32'(host_drdy_n), 32'(md == 0));
        chk(host_err_n  == (me == 0), "R8 err model", 32'(host_err_n), 32'(me == 0));
        if (cmd_pending) begin
            pend_cnt++;
            chk(!pend_prev, "R5 adjacent events", 1, 0);
        end
        pend_prev = cmd_pending;
    end

    task automatic host_write(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); host_rw = 1'b0; host_addr = a; host_dq_i = d;
        @(negedge clk); host_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(host_dq_oe == 1'b0, "R4 write cycle undriven", 32'(host_dq_oe), 0);
        repeat (3) @(negedge clk); host_cs_n = 1'b1;
        repeat (6) @(negedge clk); host_rw = 1'b1;
    endtask

    task automatic host_read(input logic [11:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); host_rw = 1'b1; host_addr = a; host_cs_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(host_dq_oe == 1'b1, "R4 read drives", 32'(host_dq_oe), 1);
        chk(host_dq_o == exp, tag, 32'(host_dq_o), 32'(exp));
        host_cs_n = 1'b1;
        #1 chk(host_dq_oe == 1'b0, "R4 release on select high", 32'(host_dq_oe), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic dev_read(input logic [11:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); dev_addr = a;
        @(posedge clk); #5;
        chk(dev_rdata == exp, tag, 32'(dev_rdata), 32'(exp));
    endtask

    // counts low cycles of both pulse outputs; optional retrigger of data-ready
    task automatic count_low(input bit retrig, output int cd, output int ce);
        cd = 0; ce = 0;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #5;
            if (i == 0) begin drdy_req = 1'b0; err_req = 1'b0; end
            if (retrig && i == 3) drdy_req = 1'b1;
            if (retrig && i == 4) drdy_req = 1'b0;
            if (!host_drdy_n) cd++;
            if (!host_err_n)  ce++;
        end
    endtask

    initial begin
        int cd, ce, base;
        host_rst_n = 1'b0; host_cs_n = 1'b0; host_rw = 1'b1; host_cmd_n = 1'b1;
        host_addr = '0; host_dq_i = '0; drdy_req = 1'b0; err_req = 1'b0;
        dev_we = 1'b0; dev_addr = '0; dev_wdata = '0;
        repeat (5) @(negedge clk);
        // R9: select low and read level during reset, nothing active
        chk(host_dq_oe == 1'b0, "R9 bus idle in reset", 32'(host_dq_oe), 0);
        chk(host_drdy_n && host_err_n, "R9 pulses idle in reset", 32'({host_drdy_n, host_err_n}), 3);
        host_cs_n = 1'b1; host_rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 R2: plain writes and reads
        host_write(12'h005, 16'hA5A5);
        host_write(12'hFFF, 16'h1234);
        host_write(12'h000, 16'hFFFF);
        host_read(12'h005, 16'hA5A5, "R1 read back 0x005");
        host_read(12'hFFF, 16'h1234, "R1 read back 0xFFF");
        host_read(12'h000, 16'hFFFF, "R1 read back 0x000");

        // R2: address change during one read
        @(negedge clk); host_rw = 1'b1; host_addr = 12'h005; host_cs_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(host_dq_o == 16'hA5A5, "R2 first address", 32'(host_dq_o), 32'hA5A5);
        host_addr = 12'hFFF;
        repeat (5) @(negedge clk);
        chk(host_dq_o == 16'h1234, "R2 follows address", 32'(host_dq_o), 32'h1234);
        host_cs_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: R/W falls late inside a read cycle
        @(negedge clk); host_rw = 1'b1; host_addr = 12'h005; host_cs_n = 1'b0;
        repeat (4) @(negedge clk); host_rw = 1'b0; host_dq_i = 16'hDEAD;
        #1 chk(host_dq_oe == 1'b0, "R4 release on R/W low", 32'(host_dq_oe), 0);
        repeat (3) @(negedge clk); host_cs_n = 1'b1;
        repeat (6) @(negedge clk); host_rw = 1'b1;
        host_read(12'h005, 16'hA5A5, "R3 late R/W stores nothing");

        // R10: device port both ways
        @(negedge clk); dev_we = 1'b1; dev_addr = 12'h010; dev_wdata = 16'h0BEE;
        @(negedge clk); dev_we = 1'b0;
        host_read(12'h010, 16'h0BEE, "R10 device write seen by host");
        dev_read(12'hFFF, 16'h1234, "R10 host write seen by device");

        // R11: same-cycle, same-address collision
        @(negedge clk); host_rw = 1'b0; host_addr = 12'h020; host_dq_i = 16'h1111;
        @(negedge clk); host_cs_n = 1'b0;
        repeat (5) @(negedge clk); host_cs_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); dev_we = 1'b1; dev_addr = 12'h020; dev_wdata = 16'h2222;
        @(negedge clk); dev_we = 1'b0;
        repeat (4) @(negedge clk); host_rw = 1'b1;
        host_read(12'h020, 16'h1111, "R11 host wins collision");
        dev_read(12'h020, 16'h1111, "R11 device sees host word");

        // R5: three command strobes of different widths
        base = pend_cnt;
        @(negedge clk); host_cmd_n = 1'b0; repeat (3)  @(negedge clk); host_cmd_n = 1'b1;
        repeat (6) @(negedge clk);
        host_cmd_n = 1'b0; repeat (2)  @(negedge clk); host_cmd_n = 1'b1;
        repeat (6) @(negedge clk);
        host_cmd_n = 1'b0; repeat (12) @(negedge clk); host_cmd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(pend_cnt - base == 3, "R5 one event per strobe", 32'(pend_cnt - base), 3);

        // R6: single request
        @(negedge clk); drdy_req = 1'b1;
        count_low(1'b0, cd, ce);
        chk(cd == P, "R6 pulse width", 32'(cd), 32'(P));
        chk(ce == 0, "R8 error untouched", 32'(ce), 0);

        // R7: retrigger restarts full width
        @(negedge clk); drdy_req = 1'b1;
        count_low(1'b1, cd, ce);
        chk(cd == P + 4, "R7 retrigger width", 32'(cd), 32'(P + 4));

        // R8: both requests in one cycle, then error alone
        @(negedge clk); drdy_req = 1'b1; err_req = 1'b1;
        count_low(1'b0, cd, ce);
        chk(cd == P && ce == P, "R8 simultaneous", 32'({cd[15:0], ce[15:0]}), 32'({16'(P), 16'(P)}));
        @(negedge clk); err_req = 1'b1;
        count_low(1'b0, cd, ce);
        chk(ce == P && cd == 0, "R8 error alone", 32'({cd[15:0], ce[15:0]}), 32'(P));

        // R9: reset in the middle of a pulse
        @(negedge clk); drdy_req = 1'b1;
        @(negedge clk); drdy_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(host_drdy_n == 1'b0, "R6 pulse active before reset", 32'(host_drdy_n), 0);
        host_rst_n = 1'b0; host_cs_n = 1'b0; host_rw = 1'b1;
        #1;
        chk(host_drdy_n == 1'b1, "R9 pulse cleared by reset", 32'(host_drdy_n), 1);
        chk(host_dq_oe == 1'b0, "R9 bus idle in reset", 32'(host_dq_oe), 0);
        repeat (3) @(negedge clk);
        host_cs_n = 1'b1; host_rst_n = 1'b1;
        repeat (5) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule